// File: doc/BRIEF.md
# Three-Lane Balanced-Frame Deserializer

This block rebuilds a 21-bit parallel word from three serial lanes that all run on one bit clock. Each lane delivers one fixed-length frame per word. A frame-start pulse marks the first serial bit of every frame, and all three lanes shift in lockstep.

A mode input picks between two framings:

- **Balanced framing.** Each lane frame is nine bits long. Two polarity flag bits come first, followed by seven payload bits. The flags tell whether the transmitter sent the payload inverted, and the block undoes that inversion. An illegal flag pair is reported on a per-lane error output.
- **Plain framing.** Each lane frame is just seven payload bits.

When a frame completes, the block registers the word and raises a one-cycle valid strobe. An input option chooses which clock edge launches that strobe, so the downstream logic can capture on the rising or the falling edge. The mode is sampled only when a frame starts. The first frame after a mode change is thrown away.

Top module: `deser3_top`

## Requirements
- R1: When `balanced_mode` is 1 at a frame start, each lane frame is 9 bits in this order: flag A, then flag B, then payload bits 6 down to 0. A=1,B=0 means the payload was inverted and is complemented on output. A=0,B=1 means it is passed as received.
- R2: When `balanced_mode` is 0 at a frame start, each lane frame is 7 payload bits, bit 6 first and bit 0 last. They are output unchanged, and `flag_err` is 0 for that word.
- R3: Lane 0 fills `word_out[6:0]`, lane 1 fills `word_out[13:7]` and lane 2 fills `word_out[20:14]`.
- R4: In balanced framing, a flag pair of 00 or 11 on a lane sets that lane's bit of `flag_err` for that word. That lane's payload is passed through as received, without being complemented.
- R5: `word_valid` is high for exactly one bit-clock cycle per accepted frame. `word_out` and `flag_err` change only together with that strobe and hold their value until the next accepted frame.
- R6: If the mode sampled at a frame start differs from the mode of the previous frame, that frame produces no strobe and leaves `word_out` unchanged. The frame that follows it is accepted normally.
- R7: Toggling `balanced_mode` after a frame start has no effect on that frame's length or decoding.
- R8: With `strobe_fall` at 0, `word_valid` rises just after the rising edge on which the last bit is sampled. With `strobe_fall` at 1, `word_valid` rises at the following falling edge and stays high until the next falling edge.
- R9: A `frame_start` pulse that arrives before the current frame has completed abandons that frame. Framing restarts from the new pulse, and the abandoned frame produces no strobe.
- R10: While `rst` is high, `word_out`, `flag_err` and `word_valid` are 0. Serial bits that arrive before the first `frame_start` produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; every lane bit is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| balanced_mode | input | 1 | 1 = 9-bit balanced framing, 0 = 7-bit plain framing; sampled at frame start |
| strobe_fall | input | 1 | 0 = valid launched on the rising edge, 1 = on the falling edge |
| frame_start | input | 1 | High during the first serial bit of a frame |
| lane_in | input | 3 | One serial bit per lane |
| word_out | output | 21 | Recovered parallel word |
| word_valid | output | 1 | One-cycle strobe marking a new word |
| flag_err | output | 3 | Per-lane illegal-flag indication, held with the word |

## Verification
The bench sweeps 128 payload patterns with every combination of per-lane inversion in both framings. A design that reversed the bit order, swapped lanes or misread which flag means "inverted" would corrupt nearly every word. All eight combinations of illegal flag pairs are sent so that each lane's error bit is seen on its own. A design that complemented bad groups, or reported the error on the wrong lane, would fail here.

Mode switches check that the frame after a change is dropped while `word_out` holds. A design that kept the stale frame length would misalign every later word. Mid-frame mode toggles, early frame-start pulses and the rising/falling strobe timing are each probed, because those would slip a bit, emit a spurious word, or raise the strobe half a cycle off.

// File: rtl/deser3_pkg.sv
package deser3_pkg;

    localparam int LANES     = 3;
    localparam int GRP_W     = 7;
    localparam int FLAG_W    = 2;
    localparam int FRM_BAL   = GRP_W + FLAG_W;
    localparam int FRM_PLAIN = GRP_W;
    localparam int WORD_W    = LANES * GRP_W;
    localparam int CNT_W     = $clog2(FRM_BAL + 1);

    typedef enum logic {
        FRAMING_PLAIN = 1'b0,
        FRAMING_BAL   = 1'b1
    } framing_e;

    typedef enum logic [FLAG_W-1:0] {
        POL_BAD_LO = 2'b00,
        POL_TRUE   = 2'b01,
        POL_INV    = 2'b10,
        POL_BAD_HI = 2'b11
    } flagpair_e;

    typedef struct packed {
        logic             err;
        logic [GRP_W-1:0] data;
    } group_t;

    // Decode one lane frame; raw holds the bits with the first received bit at the MSB.
    function automatic group_t restore_group(framing_e f, logic [FRM_BAL-1:0] raw);
        group_t    g;
        flagpair_e fp;
        fp     = flagpair_e'(raw[FRM_BAL-1 -: FLAG_W]);
        g.err  = 1'b0;
        g.data = raw[GRP_W-1:0];
        if (f == FRAMING_BAL) begin
            case (fp)
                POL_INV:  g.data = ~raw[GRP_W-1:0];
                POL_TRUE: g.data = raw[GRP_W-1:0];
                default:  g.err  = 1'b1;
            endcase
        end
        return g;
    endfunction

    function automatic logic [CNT_W-1:0] frame_len(framing_e f);
        return (f == FRAMING_BAL) ? CNT_W'(FRM_BAL) : CNT_W'(FRM_PLAIN);
    endfunction

endpackage

// File: rtl/deser3_framer.sv
module deser3_framer
    import deser3_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     frame_start,
    input  logic     mode_in,
    output logic     shift_en,
    output logic     capture,
    output framing_e framing
);

    logic             in_frame_q;
    logic [CNT_W-1:0] cnt_q;
    framing_e         frame_mode_q;
    logic             mode_known_q;
    logic             discard_q;

    logic [CNT_W-1:0] bit_idx;
    framing_e         cur_mode;
    logic             cur_discard;
    logic             active;
    logic             last_bit;

    always_comb begin
        bit_idx     = frame_start ? '0 : cnt_q;
        cur_mode    = frame_start ? framing_e'(mode_in) : frame_mode_q;
        cur_discard = frame_start ? (mode_known_q && (framing_e'(mode_in) != frame_mode_q))
                                  : discard_q;
        active      = frame_start | in_frame_q;
        last_bit    = active && (bit_idx == frame_len(cur_mode) - CNT_W'(1));
    end

    assign shift_en = active;
    assign capture  = last_bit && !cur_discard;
    assign framing  = cur_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_q   <= 1'b0;
            cnt_q        <= '0;
            frame_mode_q <= FRAMING_BAL;
            mode_known_q <= 1'b0;
            discard_q    <= 1'b0;
        end else begin
            if (frame_start) begin
                frame_mode_q <= framing_e'(mode_in);
                mode_known_q <= 1'b1;
                discard_q    <= cur_discard;
            end
            if (active) begin
                if (last_bit) begin
                    in_frame_q <= 1'b0;
                    cnt_q      <= '0;
                end else begin
                    in_frame_q <= 1'b1;
                    cnt_q      <= bit_idx + CNT_W'(1);
                end
            end
        end
    end

    assert_cnt_range_R9: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(FRM_BAL));

    assert_discard_on_change_R6: assert property (@(posedge clk) disable iff (rst)
        (frame_start && mode_known_q && (framing_e'(mode_in) != frame_mode_q)) |=> discard_q);

    assert_mode_held_R7: assert property (@(posedge clk) disable iff (rst)
        (in_frame_q && !frame_start) |=> $stable(frame_mode_q));

endmodule

// File: rtl/deser3_lane.sv
module deser3_lane
    import deser3_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     shift_en,
    input  logic     ser_in,
    input  framing_e framing,
    output group_t   grp
);

    logic [FRM_BAL-2:0] sr_q;
    logic [FRM_BAL-1:0] raw;

    // The bit on ser_in this cycle completes the frame when capture is high.
    assign raw = {sr_q, ser_in};
    assign grp = restore_group(framing, raw);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (shift_en) begin
            sr_q <= raw[FRM_BAL-2:0];
        end
    end

endmodule

// File: rtl/deser3_outreg.sv
module deser3_outreg
    import deser3_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  framing_e          framing,
    input  group_t            grps [LANES],
    input  logic              strobe_fall,
    output logic [WORD_W-1:0] word,
    output logic [LANES-1:0]  err,
    output logic              valid
);

    logic [WORD_W-1:0] word_q;
    logic [LANES-1:0]  err_q;
    logic              valid_rise_q;
    logic              valid_fall_q;
    logic [WORD_W-1:0] word_d;
    logic [LANES-1:0]  err_d;

    for (genvar i = 0; i < LANES; i++) begin : g_map
        assign word_d[i*GRP_W +: GRP_W] = grps[i].data;
        assign err_d[i]                 = grps[i].err;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q       <= '0;
            err_q        <= '0;
            valid_rise_q <= 1'b0;
        end else begin
            valid_rise_q <= capture;
            if (capture) begin
                word_q <= word_d;
                err_q  <= err_d;
            end
        end
    end

    // Falling-edge relaunch of the strobe for downstream falling-edge capture.
    always_ff @(negedge clk) begin
        if (rst) begin
            valid_fall_q <= 1'b0;
        end else begin
            valid_fall_q <= valid_rise_q;
        end
    end

    assign word  = word_q;
    assign err   = err_q;
    assign valid = strobe_fall ? valid_fall_q : valid_rise_q;

    assert_single_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        valid_rise_q |=> !valid_rise_q);

    assert_word_moves_with_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        (word_q != $past(word_q)) |-> valid_rise_q);

    assert_plain_no_err_R2: assert property (@(posedge clk) disable iff (rst)
        (capture && framing == FRAMING_PLAIN) |=> (err_q == '0));

endmodule

// File: rtl/deser3_top.sv
module deser3_top
    import deser3_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              balanced_mode,
    input  logic              strobe_fall,
    input  logic              frame_start,
    input  logic [LANES-1:0]  lane_in,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid,
    output logic [LANES-1:0]  flag_err
);

    logic     shift_en;
    logic     capture;
    framing_e framing;
    group_t   grps [LANES];

    deser3_framer u_framer (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .mode_in     (balanced_mode),
        .shift_en    (shift_en),
        .capture     (capture),
        .framing     (framing)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        deser3_lane u_lane (
            .clk      (clk),
            .rst      (rst),
            .shift_en (shift_en),
            .ser_in   (lane_in[i]),
            .framing  (framing),
            .grp      (grps[i])
        );
    end

    deser3_outreg u_out (
        .clk         (clk),
        .rst         (rst),
        .capture     (capture),
        .framing     (framing),
        .grps        (grps),
        .strobe_fall (strobe_fall),
        .word        (word_out),
        .err         (flag_err),
        .valid       (word_valid)
    );

    assert_reset_quiet_R10: assert property (@(posedge clk)
        $past(rst) |-> (!word_valid || strobe_fall) && (word_out == '0 || !$past(rst, 2)));

endmodule

// File: tb/tb_deser3_top.sv
module tb_deser3_top;

    localparam int PERIOD = 10;
    localparam int MAXREC = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        balanced_mode = 1'b1;
    logic        strobe_fall = 1'b0;
    logic        frame_start = 1'b0;
    logic [2:0]  lane_in = '0;
    logic [20:0] word_out;
    logic        word_valid;
    logic [2:0]  flag_err;

    int checks = 0;
    int errors = 0;

    deser3_top dut (
        .clk           (clk),
        .rst           (rst),
        .balanced_mode (balanced_mode),
        .strobe_fall   (strobe_fall),
        .frame_start   (frame_start),
        .lane_in       (lane_in),
        .word_out      (word_out),
        .word_valid    (word_valid),
        .flag_err      (flag_err)
    );

    always #(PERIOD/2) clk = ~clk;

    // Records seen by the monitor
    logic [20:0] rec_word [MAXREC];
    logic [2:0]  rec_err  [MAXREC];
    logic        rec_early[MAXREC];
    logic        rec_late [MAXREC];
    int          nrec = 0;
    logic        pend = 1'b0;
    logic        mon_en = 1'b0;

    // Expected records
    logic [20:0] exp_word [MAXREC];
    logic [2:0]  exp_err  [MAXREC];
    logic        exp_fall [MAXREC];
    int          nexp = 0;

    logic        mode_known = 1'b0;
    logic        last_mode  = 1'b1;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: samples at +3 (before the falling edge) and +7 (after it)
    always @(posedge clk) begin
        logic s3, s7;
        #3;
        s3 = word_valid;
        if (pend) begin
            rec_late[nrec-1] = s3;
            pend = 1'b0;
        end
        #4;
        s7 = word_valid;
        if (mon_en) begin
            if (s7) begin
                if (nrec < MAXREC) begin
                    rec_word[nrec]  = word_out;
                    rec_err[nrec]   = flag_err;
                    rec_early[nrec] = s3;
                    rec_late[nrec]  = 1'b0;
                    nrec++;
                    pend = 1'b1;
                end
            end else if (nrec > 0) begin
                // R5: word holds between strobes
                check(word_out == rec_word[nrec-1], "R5 word held", word_out, rec_word[nrec-1]);
            end
        end
    end

    task automatic drive(input logic fs, input logic [2:0] bits);
        frame_start = fs;
        lane_in     = bits;
        @(posedge clk);
        #2;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 3'(i * 5 + 3));
    endtask

    task automatic send_frame(input logic bal, input logic [20:0] d, input logic [2:0] inv,
                              input logic [2:0] bad, input logic wiggle);
        logic [8:0] fv [3];
        int         len;
        logic       disc;
        for (int l = 0; l < 3; l++) begin
            logic [6:0] g;
            g = d[l*7 +: 7];
            if (!bal)        fv[l] = {2'b00, g};
            else if (bad[l]) fv[l] = {inv[l] ? 2'b11 : 2'b00, g};
            else if (inv[l]) fv[l] = {2'b10, ~g};
            else             fv[l] = {2'b01, g};
        end
        disc       = mode_known && (bal != last_mode);
        mode_known = 1'b1;
        last_mode  = bal;
        len        = bal ? 9 : 7;
        balanced_mode = bal;
        for (int b = 0; b < len; b++) begin
            logic [2:0] bits;
            for (int l = 0; l < 3; l++) bits[l] = bal ? fv[l][8-b] : fv[l][6-b];
            if (wiggle && b == 1) balanced_mode = ~bal;
            drive(b == 0, bits);
        end
        balanced_mode = bal;
        if (!disc) begin
            exp_word[nexp] = d;
            exp_err[nexp]  = bal ? bad : 3'b000;
            exp_fall[nexp] = strobe_fall;
            nexp++;
        end
    endtask

    task automatic send_partial(input logic bal, input int k);
        mode_known    = 1'b1;
        last_mode     = bal;
        balanced_mode = bal;
        for (int b = 0; b < k; b++) drive(b == 0, 3'(b + 1));
    endtask

    function automatic logic [20:0] pat(input int v);
        logic [6:0] a;
        a = 7'(v);
        return {~a, 7'(v * 3 + 1), a};
    endfunction

    initial begin
        #(PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(posedge clk);
        #2;
        check(word_out == '0, "R10 reset word", word_out, 0);
        check(word_valid == 1'b0, "R10 reset valid", word_valid, 0);
        check(flag_err == '0, "R10 reset err", flag_err, 0);
        rst = 1'b0;
        mon_en = 1'b1;
        // R10: bits before the first frame marker are ignored
        idle(20);
        check(nrec == 0, "R10 no strobe before frame_start", nrec, 0);
        check(word_out == '0, "R10 word before frame_start", word_out, 0);

        // R1 R3: balanced sweep with every inversion combination
        for (int v = 0; v < 128; v++) send_frame(1'b1, pat(v), 3'(v), 3'b000, 1'b0);
        // R4: illegal flag pairs on every lane combination
        for (int c = 0; c < 8; c++) send_frame(1'b1, pat(c * 17 + 5), ~3'(c), 3'(c), 1'b0);
        idle(3);
        // R6: switch to plain, first frame dropped; R2 plain sweep
        for (int v = 0; v < 128; v++) send_frame(1'b0, pat(v + 40), 3'b000, 3'b000, 1'b0);
        // R7: mode toggled mid-frame in plain mode
        for (int v = 0; v < 4; v++) send_frame(1'b0, pat(v * 29), 3'b000, 3'b000, 1'b1);
        // R6: back to balanced, first frame dropped
        for (int v = 0; v < 16; v++) send_frame(1'b1, pat(v * 7 + 2), 3'(v + 1), 3'b000, 1'b0);
        // R7: mode toggled mid-frame in balanced mode
        for (int v = 0; v < 4; v++) send_frame(1'b1, pat(v * 11 + 9), 3'(v), 3'b000, 1'b1);
        // R9: early frame_start abandons a frame
        send_partial(1'b1, 4);
        send_frame(1'b1, pat(77), 3'b101, 3'b000, 1'b0);
        idle(2);
        send_partial(1'b1, 8);
        send_frame(1'b1, pat(91), 3'b010, 3'b000, 1'b0);
        // R8: falling-edge strobe
        idle(2);
        strobe_fall = 1'b1;
        idle(2);
        for (int v = 0; v < 16; v++) send_frame(1'b1, pat(v * 5 + 60), 3'(v), 3'b000, 1'b0);
        idle(2);
        strobe_fall = 1'b0;
        idle(2);
        send_frame(1'b1, pat(3), 3'b111, 3'b000, 1'b0);
        idle(6);

        check(nrec == nexp, "R5 R6 R9 strobe count", nrec, nexp);
        for (int i = 0; i < nexp && i < nrec; i++) begin
            check(rec_word[i] == exp_word[i], "R1 R2 R3 word", rec_word[i], exp_word[i]);
            check(rec_err[i] == exp_err[i], "R4 flag_err", rec_err[i], exp_err[i]);
            check(rec_early[i] == !exp_fall[i], "R8 strobe before falling edge",
                  rec_early[i], !exp_fall[i]);
            check(rec_late[i] == exp_fall[i], "R8 strobe in next cycle",
                  rec_late[i], exp_fall[i]);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule